// File: doc/BRIEF.md
# FIFO Threshold Bus-Request Controller

This block is the control logic beside a 16-byte staging FIFO that sits between a serial network engine and a local-memory DMA. It tracks how many bytes the FIFO holds and decides when to raise a bus request toward the memory side. In receive direction the serial engine pushes single bytes and the DMA pops one bus unit at a time. A bus unit is one byte on a byte-wide bus and two bytes on a word-wide bus. The request is raised one bus unit beyond a programmable threshold and held for the whole burst. At end of packet the request also drains a final partial word.

In transmit direction the DMA pushes one bus unit at a time and the serial engine pops bytes. A transmit-start pulse opens a prefetch that fills the FIFO to the threshold. The block then keeps the request low until the frame delimiter has gone out. After that it refills whenever free space reaches the threshold, and it never requests while the FIFO is full.

The state machine has eight named states:
- Receive states: `S_RX_FILL` (waiting for data), `S_RX_BURST` (requesting) and `S_RX_FLUSH` (end-of-packet drain).
- Transmit states: `S_TX_IDLE`, `S_TX_PREFETCH`, `S_TX_WAIT_SFD`, `S_TX_RUN` (no request) and `S_TX_REFILL` (requesting).

The state transitions are:
- `S_RX_FILL`→`S_RX_BURST` when the trigger level is reached.
- `S_RX_BURST`→`S_RX_FILL` when less than one bus unit remains.
- `S_RX_FILL`/`S_RX_BURST`→`S_RX_FLUSH` on end of packet with data left.
- `S_RX_FLUSH`→`S_RX_FILL` when the FIFO is empty.
- `S_TX_IDLE`→`S_TX_PREFETCH` on transmit start.
- `S_TX_PREFETCH`→`S_TX_WAIT_SFD` when the threshold is reached.
- `S_TX_WAIT_SFD`→`S_TX_REFILL` or `S_TX_RUN` on the delimiter pulse.
- `S_TX_RUN`↔`S_TX_REFILL`, driven by free space.
- `S_TX_RUN`/`S_TX_REFILL`→`S_TX_IDLE` on end of packet.
- Any state → the idle state of the other direction when the direction input changes.

Top module: `fifo_breq_ctrl`

## Requirements
- R1: After reset `breq`, `ovf` and `unf` are 0 and `occupancy` is 0.
- R2: Occupancy rises by 1 per serial push, or by one bus unit per memory push. It falls by 1 per serial pop, or by one bus unit per memory pop. A byte-mode push and pop in the same cycle leave it unchanged.
- R3: An access that would take occupancy above 16, or a pop from an empty FIFO, pulses `ovf` or `unf` for one cycle and leaves occupancy unchanged.
- R4: `thr_sel` encodes the threshold as 0→2, 1→4, 2→8 and 3→12 bytes.
- R5: In receive byte mode, `breq` rises in the cycle after the push that brings occupancy to threshold+1 (the 9th byte for 8).
- R6: In receive word mode, `breq` rises after the push that brings occupancy to threshold+2 (the 10th byte for 8).
- R7: A receive burst ends, with `breq` low, once occupancy falls below one bus unit.
- R8: On `eop` in receive direction with data left, `breq` is held until the FIFO is empty. A word pop of a single remaining byte removes just that byte without `unf`.
- R9: A `tx_start` pulse raises `breq` until occupancy reaches the threshold.
- R10: After the prefetch, `breq` stays low until `sfd_sent`, whatever the occupancy does meanwhile.
- R11: After `sfd_sent`, `breq` is high whenever free space is at least the threshold. It stays high until less than one bus unit is free, and it is low while the FIFO is full.
- R12: `eop` in transmit direction drops `breq` and returns to transmit idle.
- R13: A change of `tx_dir` drops `breq` in the next cycle and enters the idle state of the new direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_dir | input | 1 | 1 = transmit direction, 0 = receive |
| word_mode | input | 1 | 1 = memory bus moves two bytes per access |
| thr_sel | input | 2 | Threshold code (R4) |
| push | input | 1 | FIFO write strobe (serial side in receive, memory side in transmit) |
| pop | input | 1 | FIFO read strobe (memory side in receive, serial side in transmit) |
| tx_start | input | 1 | Pulse: begin transmit prefetch |
| sfd_sent | input | 1 | Pulse: frame delimiter has been sent |
| eop | input | 1 | Pulse: end of packet |
| breq | output | 1 | Bus request to memory side |
| occupancy | output | 5 | Bytes held in the FIFO, 0..16 |
| ovf | output | 1 | One-cycle overflow flag |
| unf | output | 1 | One-cycle underflow flag |

## Verification
Counting and request decisions coincide: a push and a pop in the same cycle must net out before the trigger comparison. Requests therefore follow the post-update occupancy, not the stale one. The bench drives simultaneous push and pop while a burst is pending and checks that both the count and `breq` agree with the net change. It also drives a word pop of a lone byte during an end-of-packet flush, where the clamped removal and the flush exit share a cycle. There `unf` must stay low while `breq` falls on the same edge that empties the FIFO.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

    // Controller states, receive family first, then transmit family
    typedef enum logic [3:0] {
        S_RX_FILL     = 4'd0,
        S_RX_BURST    = 4'd1,
        S_RX_FLUSH    = 4'd2,
        S_TX_IDLE     = 4'd8,
        S_TX_PREFETCH = 4'd9,
        S_TX_WAIT_SFD = 4'd10,
        S_TX_RUN      = 4'd11,
        S_TX_REFILL   = 4'd12
    } fbr_state_t;

    // Bit 3 of the encoding marks the transmit family
    function automatic logic fbr_is_tx(input fbr_state_t s);
        return s[3];
    endfunction

endpackage

// File: rtl/fbr_thresh.sv
module fbr_thresh #(
    parameter int CNT_W = 5
) (
    input  logic [1:0]       thr_sel,
    input  logic             word_mode,
    output logic [CNT_W-1:0] thr_bytes,
    output logic [CNT_W-1:0] unit_bytes,
    output logic [CNT_W-1:0] trig_bytes
);

    localparam logic [CNT_W-1:0] UNIT_BYTE = CNT_W'(1);
    localparam logic [CNT_W-1:0] UNIT_WORD = CNT_W'(2);

    // Threshold code decode: smallest code is a special case, the rest are multiples of four
    always_comb begin
        unique case (thr_sel)
            2'd0:    thr_bytes = CNT_W'(2);
            2'd1:    thr_bytes = CNT_W'(4);
            2'd2:    thr_bytes = CNT_W'(8);
            default: thr_bytes = CNT_W'(12);
        endcase
    end

    // One memory-bus access moves this many bytes
    assign unit_bytes = word_mode ? UNIT_WORD : UNIT_BYTE;

    // Receive request fires one bus unit past the threshold
    assign trig_bytes = thr_bytes + unit_bytes;

endmodule

// File: rtl/fbr_occ.sv
module fbr_occ #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_dir,
    input  logic             push,
    input  logic             pop,
    input  logic [CNT_W-1:0] unit_bytes,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             ovf,
    output logic             unf
);

    localparam int SW = CNT_W + 1;
    localparam logic [SW-1:0] DEPTH_W = SW'(DEPTH);

    logic [SW-1:0] inc;
    logic [SW-1:0] dec;
    logic [SW-1:0] avail;
    logic [SW-1:0] res;
    logic          ovf_try;
    logic          unf_try;

    // Writes come from memory (one unit) when transmitting, from serial (one byte) when receiving
    always_comb begin
        inc = '0;
        if (push) begin
            inc = tx_dir ? {1'b0, unit_bytes} : SW'(1);
        end
    end

    assign avail = {1'b0, cnt} + inc;

    // Reads go to memory when receiving; a trailing partial word is clamped
    always_comb begin
        dec = '0;
        if (pop) begin
            if (tx_dir) begin
                dec = SW'(1);
            end else if ({1'b0, unit_bytes} < avail) begin
                dec = {1'b0, unit_bytes};
            end else begin
                dec = avail;
            end
        end
    end

    assign unf_try = pop && (avail == '0);
    assign res     = avail - dec;
    assign ovf_try = !unf_try && (res > DEPTH_W);

    always_comb begin
        if (ovf_try || unf_try) begin
            cnt_nxt = cnt;
        end else begin
            cnt_nxt = res[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            cnt <= cnt_nxt;
            ovf <= ovf_try;
            unf <= unf_try;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cnt} <= DEPTH_W); // R3

    AST_FLAG_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf || unf) |-> (cnt == $past(cnt))); // R3

    AST_PUSH_POP_NET: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && unit_bytes == CNT_W'(1) && cnt != '0) |=> (cnt == $past(cnt))); // R2

endmodule

// File: rtl/fbr_fsm.sv
module fbr_fsm
    import fbr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_dir,
    input  logic             tx_start,
    input  logic             sfd_sent,
    input  logic             eop,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] thr_bytes,
    input  logic [CNT_W-1:0] unit_bytes,
    input  logic [CNT_W-1:0] trig_bytes,
    output logic             breq
);

    localparam logic [CNT_W:0] DEPTH_W = (CNT_W + 1)'(DEPTH);

    fbr_state_t state;
    fbr_state_t state_nxt;
    logic [CNT_W:0] free_nxt;
    logic           have_data;
    logic           at_trig;
    logic           at_thr;
    logic           room_thr;
    logic           room_unit;

    // All decisions look at the occupancy that this edge will load
    assign free_nxt  = DEPTH_W - {1'b0, cnt_nxt};
    assign have_data = (cnt_nxt != '0);
    assign at_trig   = (cnt_nxt >= trig_bytes);
    assign at_thr    = (cnt_nxt >= thr_bytes);
    assign room_thr  = (free_nxt >= {1'b0, thr_bytes});
    assign room_unit = (free_nxt >= {1'b0, unit_bytes});

    // Next-state logic
    always_comb begin
        state_nxt = state;
        if (tx_dir != fbr_is_tx(state)) begin
            state_nxt = tx_dir ? S_TX_IDLE : S_RX_FILL;
        end else begin
            unique case (state)
                S_RX_FILL: begin
                    if (eop && have_data) begin
                        state_nxt = S_RX_FLUSH;
                    end else if (at_trig) begin
                        state_nxt = S_RX_BURST;
                    end
                end
                S_RX_BURST: begin
                    if (eop) begin
                        state_nxt = have_data ? S_RX_FLUSH : S_RX_FILL;
                    end else if (cnt_nxt < unit_bytes) begin
                        state_nxt = S_RX_FILL;
                    end
                end
                S_RX_FLUSH: begin
                    if (!have_data) begin
                        state_nxt = S_RX_FILL;
                    end
                end
                S_TX_IDLE: begin
                    if (tx_start) begin
                        state_nxt = at_thr ? S_TX_WAIT_SFD : S_TX_PREFETCH;
                    end
                end
                S_TX_PREFETCH: begin
                    if (at_thr) begin
                        state_nxt = S_TX_WAIT_SFD;
                    end
                end
                S_TX_WAIT_SFD: begin
                    if (sfd_sent) begin
                        state_nxt = room_thr ? S_TX_REFILL : S_TX_RUN;
                    end
                end
                S_TX_RUN: begin
                    if (eop) begin
                        state_nxt = S_TX_IDLE;
                    end else if (room_thr) begin
                        state_nxt = S_TX_REFILL;
                    end
                end
                S_TX_REFILL: begin
                    if (eop) begin
                        state_nxt = S_TX_IDLE;
                    end else if (!room_unit) begin
                        state_nxt = S_TX_RUN;
                    end
                end
                default: state_nxt = tx_dir ? S_TX_IDLE : S_RX_FILL;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_RX_FILL;
        end else begin
            state <= state_nxt;
        end
    end

    // Output decode
    always_comb begin
        unique case (state)
            S_RX_BURST, S_RX_FLUSH, S_TX_PREFETCH, S_TX_REFILL: breq = 1'b1;
            default:                                            breq = 1'b0;
        endcase
    end

    AST_RX_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RX_FILL && !tx_dir && !eop && at_trig) |=> breq); // R5

    AST_PREFETCH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TX_PREFETCH && tx_dir && at_thr) |=> !breq); // R9

    AST_SFD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TX_WAIT_SFD && tx_dir && !sfd_sent) |=> !breq); // R10

    AST_DIR_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_dir != fbr_is_tx(state)) |=> !breq); // R13

endmodule

// File: rtl/fifo_breq_ctrl.sv
module fifo_breq_ctrl #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_dir,
    input  logic             word_mode,
    input  logic [1:0]       thr_sel,
    input  logic             push,
    input  logic             pop,
    input  logic             tx_start,
    input  logic             sfd_sent,
    input  logic             eop,
    output logic             breq,
    output logic [CNT_W-1:0] occupancy,
    output logic             ovf,
    output logic             unf
);

    logic [CNT_W-1:0] thr_bytes;
    logic [CNT_W-1:0] unit_bytes;
    logic [CNT_W-1:0] trig_bytes;
    logic [CNT_W-1:0] cnt_nxt;

    fbr_thresh #(
        .CNT_W (CNT_W)
    ) u_thresh (
        .thr_sel    (thr_sel),
        .word_mode  (word_mode),
        .thr_bytes  (thr_bytes),
        .unit_bytes (unit_bytes),
        .trig_bytes (trig_bytes)
    );

    fbr_occ #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_occ (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_dir     (tx_dir),
        .push       (push),
        .pop        (pop),
        .unit_bytes (unit_bytes),
        .cnt        (occupancy),
        .cnt_nxt    (cnt_nxt),
        .ovf        (ovf),
        .unf        (unf)
    );

    fbr_fsm #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_dir     (tx_dir),
        .tx_start   (tx_start),
        .sfd_sent   (sfd_sent),
        .eop        (eop),
        .cnt_nxt    (cnt_nxt),
        .thr_bytes  (thr_bytes),
        .unit_bytes (unit_bytes),
        .trig_bytes (trig_bytes),
        .breq       (breq)
    );

    AST_TX_FULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_dir && $past(tx_dir) && occupancy == CNT_W'(DEPTH)) |-> !breq); // R11

endmodule

// File: tb/fifo_breq_ctrl_test.sv
`timescale 1ns/1ps
module fifo_breq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_dir = 1'b0;
    logic       word_mode = 1'b0;
    logic [1:0] thr_sel = 2'd2;
    logic       push = 1'b0;
    logic       pop = 1'b0;
    logic       tx_start = 1'b0;
    logic       sfd_sent = 1'b0;
    logic       eop = 1'b0;
    logic       breq;
    logic [4:0] occupancy;
    logic       ovf;
    logic       unf;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fifo_breq_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_dir    (tx_dir),
        .word_mode (word_mode),
        .thr_sel   (thr_sel),
        .push      (push),
        .pop       (pop),
        .tx_start  (tx_start),
        .sfd_sent  (sfd_sent),
        .eop       (eop),
        .breq      (breq),
        .occupancy (occupancy),
        .ovf       (ovf),
        .unf       (unf)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit dir, input bit wm, input logic [1:0] sel);
        @(negedge clk);
        rst_n = 1'b0;
        tx_dir = dir;
        word_mode = wm;
        thr_sel = sel;
        push = 0; pop = 0; tx_start = 0; sfd_sent = 0; eop = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic strobe(input bit p, input bit q, input int n);
        for (int i = 0; i < n; i++) begin
            push = p;
            pop = q;
            @(negedge clk);
        end
        push = 0;
        pop = 0;
    endtask

    task automatic pulse_eop();
        eop = 1; @(negedge clk); eop = 0;
    endtask

    task automatic t_reset();
        do_reset(0, 0, 2'd2);
        check("R1 breq", breq, 0);
        check("R1 occupancy", occupancy, 0);
        check("R1 ovf", ovf, 0);
        check("R1 unf", unf, 0);
    endtask

    // Byte-mode receive trigger at threshold+1 for a given code
    task automatic t_rx_byte(input logic [1:0] sel, input int thr, input string tag);
        do_reset(0, 0, sel);
        strobe(1, 0, thr);
        check({tag, " breq at threshold"}, breq, 0);
        strobe(1, 0, 1);
        check({tag, " breq one past threshold"}, breq, 1);
        check("R2 occupancy after byte pushes", occupancy, thr + 1);
    endtask

    task automatic t_rx_word();
        do_reset(0, 1, 2'd2);
        strobe(1, 0, 9);
        check("R6 breq at 9th byte", breq, 0);
        strobe(1, 0, 1);
        check("R6 breq at 10th byte", breq, 1);
        strobe(1, 0, 1);
        strobe(0, 1, 4);
        check("R2 word pops", occupancy, 3);
        check("R7 breq with 3 bytes", breq, 1);
        strobe(0, 1, 1);
        check("R7 breq below one word", breq, 0);
        check("R7 occupancy", occupancy, 1);
        pulse_eop();
        check("R8 flush breq", breq, 1);
        strobe(0, 1, 1);
        check("R8 flush breq after last byte", breq, 0);
        check("R8 occupancy empty", occupancy, 0);
        check("R8 no underflow on partial word", unf, 0);
    endtask

    task automatic t_rx_simul();
        do_reset(0, 0, 2'd2);
        strobe(1, 0, 8);
        strobe(1, 1, 3);
        check("R2 simultaneous push pop count", occupancy, 8);
        check("R2 simultaneous push pop breq", breq, 0);
        strobe(1, 0, 1);
        check("R5 trigger after simultaneous", breq, 1);
        strobe(0, 1, 8);
        check("R7 breq still high with 1 byte", breq, 1);
        strobe(0, 1, 1);
        check("R7 breq low at empty", breq, 0);
    endtask

    task automatic t_flags();
        do_reset(0, 0, 2'd2);
        strobe(0, 1, 1);
        check("R3 underflow flag", unf, 1);
        check("R3 occupancy held on underflow", occupancy, 0);
        @(negedge clk);
        check("R3 underflow flag one cycle", unf, 0);
        strobe(1, 0, 16);
        check("R3 full count", occupancy, 16);
        check("R3 no overflow yet", ovf, 0);
        strobe(1, 0, 1);
        check("R3 overflow flag", ovf, 1);
        check("R3 occupancy held on overflow", occupancy, 16);
        @(negedge clk);
        check("R3 overflow flag one cycle", ovf, 0);
    endtask

    task automatic t_dir_switch();
        do_reset(0, 0, 2'd1);
        strobe(1, 0, 5);
        check("R13 burst before switch", breq, 1);
        tx_dir = 1;
        @(negedge clk);
        check("R13 breq low after switch", breq, 0);
        check("R13 occupancy kept", occupancy, 5);
        tx_dir = 0;
        @(negedge clk);
        check("R13 rx idle on return", breq, 0);
        @(negedge clk);
        check("R13 rx trigger re-evaluated", breq, 1);
    endtask

    task automatic t_tx();
        do_reset(1, 0, 2'd1);
        @(negedge clk);
        check("R9 breq before start", breq, 0);
        tx_start = 1; @(negedge clk); tx_start = 0;
        check("R9 prefetch breq", breq, 1);
        strobe(1, 0, 3);
        check("R9 prefetch breq below threshold", breq, 1);
        strobe(1, 0, 1);
        check("R9 prefetch done", breq, 0);
        check("R9 prefetched bytes", occupancy, 4);
        strobe(0, 1, 1);
        repeat (3) @(negedge clk);
        check("R10 no breq before delimiter", breq, 0);
        sfd_sent = 1; @(negedge clk); sfd_sent = 0;
        check("R11 breq after delimiter", breq, 1);
        strobe(1, 0, 12);
        check("R11 breq with one free", breq, 1);
        strobe(1, 0, 1);
        check("R11 breq low when full", breq, 0);
        check("R11 occupancy full", occupancy, 16);
        strobe(0, 1, 3);
        check("R11 breq low with 3 free", breq, 0);
        strobe(0, 1, 1);
        check("R11 breq at threshold free", breq, 1);
        pulse_eop();
        check("R12 eop drops breq", breq, 0);
        repeat (2) @(negedge clk);
        check("R12 idle holds breq low", breq, 0);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rx_byte(2'd2, 8, "R5 thr8");
        t_rx_byte(2'd1, 4, "R5 thr4");
        t_rx_byte(2'd0, 2, "R4 code0");
        t_rx_byte(2'd3, 12, "R4 code3");
        t_rx_word();
        t_rx_simul();
        t_flags();
        t_dir_switch();
        t_tx();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule